// File: doc/BRIEF.md
# OTG Interrupt Status and Enable Register

This block is one register of a dual-role USB controller. It watches the ID pin level, four comparator outputs (A-device VBUS valid, A-session valid, B-session valid, B-session end) and a strobe that marks data-line pulsing. It turns the qualifying transitions of these inputs into sticky status flags. A free-running tick derived from the clock frequency raises a further flag once per millisecond. Software reads the whole register through one read/write port. It clears a flag by writing a one to it and controls interrupt generation through enable bits in the same word.

Each input passes through a synchronizer before edge detection. Edges are not detected until the synchronizer and the previous-value register hold real samples, so the levels present at reset release raise no flags. The single interrupt output combines every flag with its enable. The enables for the timer and data-pulse flags are fixed by parameters, because the register word has no room for them.

Top module: `otg_irq_reg`

## Requirements
- R1: After reset every readable bit is 0 and `irq` is 0. Input levels held high through reset release set no status bit.
- R2: Bit 16 (ID change) sets on every rising and every falling transition of `idPin`.
- R3: Bits 17, 18 and 19 set on either transition of `aVbusVld`, `aSessVld` and `bSessVld` respectively.
- R4: Bit 20 (session end) sets only when `bSessEnd` goes from 0 to 1. A fall of `bSessEnd` leaves it clear.
- R5: Bit 21 (millisecond tick) sets once every CLK_HZ/1000 clock cycles.
- R6: Bit 22 (data pulse) sets on a rising edge of `dataPulse` only while `ctrlMode` equals 2'b11 and `portPowerOn` is 0. In any other mode, or with port power on, the pulse is ignored.
- R7: A write with a 1 in any of bits 16..22 clears that status bit. A 0 in those bits leaves the bit unchanged.
- R8: When a set event and a write-one clear hit the same status bit in the same cycle, the bit ends up set.
- R9: Every write loads bits 24..28 as the enables for status bits 16..20, and they read back as written. Bits 0..15, 23 and 29..31 always read 0.
- R10: `irq` is 1 exactly when some status bit and its enable are both 1. Bits 21 and 22 use the parameters TIMER_IRQ_EN and PULSE_IRQ_EN as their enables.
- R11: An input transition made before clock edge k shows in the status bits after edge k+2 (two synchronizer stages plus the status register), and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 32 | Write data (clear mask and enables) |
| regRdata | output | 32 | Current register contents |
| idPin | input | 1 | ID pin level |
| aVbusVld | input | 1 | A-device VBUS valid comparator |
| aSessVld | input | 1 | A-session valid comparator |
| bSessVld | input | 1 | B-session valid comparator |
| bSessEnd | input | 1 | B-session end comparator |
| dataPulse | input | 1 | Data-line pulsing detect strobe |
| ctrlMode | input | 2 | Controller mode field, 2'b11 means host |
| portPowerOn | input | 1 | Port power control, 1 means on |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench holds every input high through reset. A design that compared against an unprimed previous value would raise phantom flags at release. It counts the cycles from a session-input change to its flag, so an extra or missing synchronizer stage changes the count. It collides a set event with a write-one clear on the same edge: a design that lets the clear win loses that event. It also checks that a falling session-end input, a pulse outside host mode or with port power on, and zeros in the clear mask all leave the flags alone. A design with looser edge qualification or plain write semantics would disturb them.

// File: rtl/otg_irq_pkg.sv
package otg_irq_pkg;
  localparam int NUM_ST  = 7;
  localparam int NUM_EN  = 5;
  localparam int ST_LSB  = 16;
  localparam int EN_LSB  = 24;
  localparam int NUM_IN  = 6;

  // status bit indices inside the status vector
  localparam int IDX_ID    = 0;
  localparam int IDX_AVBUS = 1;
  localparam int IDX_ASESS = 2;
  localparam int IDX_BSESS = 3;
  localparam int IDX_BEND  = 4;
  localparam int IDX_TICK  = 5;
  localparam int IDX_PULSE = 6;

  localparam logic [1:0] MODE_HOST = 2'b11;

  typedef struct packed {
    logic [NUM_ST-1:0] setMask;
    logic [NUM_ST-1:0] clrMask;
    logic              enLoad;
    logic [NUM_EN-1:0] enVal;
  } otgStrobes_t;
endpackage

// File: rtl/otg_sync_edge.sv
module otg_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic lvl,
  output logic prevLvl
);
  logic [SYNC_STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain   <= '0;
      prevLvl <= 1'b0;
    end else begin
      chain   <= {chain[SYNC_STAGES-2:0], din};
      prevLvl <= chain[SYNC_STAGES-1];
    end
  end

  assign lvl = chain[SYNC_STAGES-1];
endmodule

// File: rtl/otg_irq_ctrl.sv
module otg_irq_ctrl
  import otg_irq_pkg::*;
#(
  parameter int CLK_HZ      = 60_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [31:0]       regWdata,
  input  logic [NUM_IN-1:0] rawIn,
  input  logic [1:0]        ctrlMode,
  input  logic              portPowerOn,
  output otgStrobes_t       strb
);
  localparam int TICK_DIV = CLK_HZ / 1000;
  localparam int TICK_W   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int ARM_MAX  = SYNC_STAGES + 1;
  localparam int ARM_W    = $clog2(ARM_MAX + 1);

  logic [NUM_IN-1:0] lvl;
  logic [NUM_IN-1:0] prevLvl;
  logic [ARM_W-1:0]  armCnt;
  logic              armed;
  logic [TICK_W-1:0] tickCnt;
  logic              tick;
  logic              hostOk;
  logic [NUM_IN-1:0] chg;
  logic [NUM_IN-1:0] rise;

  for (genvar i = 0; i < NUM_IN; i++) begin : gSync
    otg_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) uSync (
      .clk    (clk),
      .rstN   (rstN),
      .din    (rawIn[i]),
      .lvl    (lvl[i]),
      .prevLvl(prevLvl[i])
    );
  end

  // edge detection held off until chain and previous value hold real samples
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         armCnt <= '0;
    else if (armCnt != ARM_W'(ARM_MAX)) armCnt <= armCnt + 1'b1;
  end
  assign armed = (armCnt == ARM_W'(ARM_MAX));

  always_comb begin
    chg  = armed ? (lvl ^ prevLvl)  : '0;
    rise = armed ? (lvl & ~prevLvl) : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                tickCnt <= '0;
    else if (tickCnt == TICK_W'(TICK_DIV - 1)) tickCnt <= '0;
    else                                      tickCnt <= tickCnt + 1'b1;
  end
  assign tick = (tickCnt == TICK_W'(TICK_DIV - 1));

  assign hostOk = (ctrlMode == MODE_HOST) && !portPowerOn;

  logic unusedWr;
  assign unusedWr = ^{regWdata[31:29], regWdata[23], regWdata[15:0]};

  always_comb begin
    strb                    = '0;
    strb.setMask[IDX_ID]    = chg[0];
    strb.setMask[IDX_AVBUS] = chg[1];
    strb.setMask[IDX_ASESS] = chg[2];
    strb.setMask[IDX_BSESS] = chg[3];
    strb.setMask[IDX_BEND]  = rise[4];
    strb.setMask[IDX_TICK]  = tick;
    strb.setMask[IDX_PULSE] = rise[5] && hostOk;
    strb.clrMask            = regWe ? regWdata[ST_LSB +: NUM_ST] : '0;
    strb.enLoad             = regWe;
    strb.enVal              = regWdata[EN_LSB +: NUM_EN];
  end

  // independent cycle count between ticks for R5
  logic [TICK_W-1:0] chkCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        chkCnt <= '0;
    else if (strb.setMask[IDX_TICK])  chkCnt <= '0;
    else                              chkCnt <= chkCnt + 1'b1;
  end

  a_r5_tick_period: assert property (@(posedge clk) disable iff (!rstN)
    strb.setMask[IDX_TICK] |-> (chkCnt == TICK_W'(TICK_DIV - 1)));

  a_r4_end_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    strb.setMask[IDX_BEND] |-> $rose(lvl[4]));

  a_r6_pulse_gated: assert property (@(posedge clk) disable iff (!rstN)
    strb.setMask[IDX_PULSE] |-> (ctrlMode == MODE_HOST && !portPowerOn));

  a_r1_quiet_until_armed: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> (strb.setMask[IDX_BEND:IDX_ID] == '0));
endmodule

// File: rtl/otg_irq_dp.sv
module otg_irq_dp
  import otg_irq_pkg::*;
#(
  parameter bit TIMER_IRQ_EN = 1'b1,
  parameter bit PULSE_IRQ_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  otgStrobes_t strb,
  output logic [31:0] regRdata,
  output logic        irq
);
  logic [NUM_ST-1:0] stat;
  logic [NUM_EN-1:0] enab;
  logic [NUM_ST-1:0] effEn;

  // set beats clear so a coincident event is kept
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stat <= '0;
    else       stat <= (stat & ~strb.clrMask) | strb.setMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            enab <= '0;
    else if (strb.enLoad) enab <= strb.enVal;
  end

  assign effEn = {PULSE_IRQ_EN, TIMER_IRQ_EN, enab};
  assign irq   = |(stat & effEn);

  always_comb begin
    regRdata                    = '0;
    regRdata[ST_LSB +: NUM_ST]  = stat;
    regRdata[EN_LSB +: NUM_EN]  = enab;
  end

  a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rstN)
    |(strb.clrMask & ~strb.setMask) |=>
      ((stat & $past(strb.clrMask & ~strb.setMask)) == '0));

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    |strb.setMask |=> ((stat & $past(strb.setMask)) == $past(strb.setMask)));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrMask == '0 && strb.setMask == '0) |=> $stable(stat));
endmodule

// File: rtl/otg_irq_reg.sv
module otg_irq_reg
  import otg_irq_pkg::*;
#(
  parameter int CLK_HZ       = 60_000_000,
  parameter int SYNC_STAGES  = 2,
  parameter bit TIMER_IRQ_EN = 1'b1,
  parameter bit PULSE_IRQ_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        idPin,
  input  logic        aVbusVld,
  input  logic        aSessVld,
  input  logic        bSessVld,
  input  logic        bSessEnd,
  input  logic        dataPulse,
  input  logic [1:0]  ctrlMode,
  input  logic        portPowerOn,
  output logic        irq
);
  otgStrobes_t strb;

  otg_irq_ctrl #(.CLK_HZ(CLK_HZ), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWe      (regWe),
    .regWdata   (regWdata),
    .rawIn      ({dataPulse, bSessEnd, bSessVld, aSessVld, aVbusVld, idPin}),
    .ctrlMode   (ctrlMode),
    .portPowerOn(portPowerOn),
    .strb       (strb)
  );

  otg_irq_dp #(.TIMER_IRQ_EN(TIMER_IRQ_EN), .PULSE_IRQ_EN(PULSE_IRQ_EN)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .regRdata(regRdata),
    .irq     (irq)
  );

  a_r10_irq_needs_status: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (regRdata[ST_LSB +: NUM_ST] != '0));

  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regRdata[15:0] == '0) && !regRdata[23] && (regRdata[31:29] == '0));
endmodule

// File: tb/sim_otg_irq_reg.sv
module sim_otg_irq_reg;
  localparam int CLK_PERIOD = 10;
  localparam int TB_CLK_HZ  = 20_000;
  localparam int TICK_DIV   = TB_CLK_HZ / 1000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        idPin = 1'b1, aVbusVld = 1'b1, aSessVld = 1'b1, bSessVld = 1'b1;
  logic        bSessEnd = 1'b1, dataPulse = 1'b0;
  logic [1:0]  ctrlMode = 2'b11;
  logic        portPowerOn = 1'b0;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;
  logic [4:0] enSh = '0;

  otg_irq_reg #(.CLK_HZ(TB_CLK_HZ), .SYNC_STAGES(2),
                .TIMER_IRQ_EN(1'b0), .PULSE_IRQ_EN(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .idPin(idPin), .aVbusVld(aVbusVld),
    .aSessVld(aSessVld), .bSessVld(bSessVld), .bSessEnd(bSessEnd),
    .dataPulse(dataPulse), .ctrlMode(ctrlMode), .portPowerOn(portPowerOn),
    .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // status without the free-running tick bit (21)
  function automatic logic [6:0] stNoTick();
    return regRdata[22:16] & 7'h5F;
  endfunction

  task automatic wrReg(input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regWdata = d;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic clearAll();
    wrReg({3'b0, enSh, 1'b0, 7'h7F, 16'h0});
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tReset();
    chk("R1 reset value", regRdata, 32'h0);
    chk("R1 reset irq", {31'b0, irq}, 32'h0);
    @(negedge clk); rstN = 1'b1;
    waitN(8);
    chk("R1 no flags from high levels at release", {25'b0, stNoTick()}, 32'h0);
  endtask

  task automatic tIdEdges();
    clearAll();
    @(negedge clk); idPin = 1'b0;
    waitN(2);
    chk("R11 not yet visible after two edges", {31'b0, regRdata[16]}, 32'h0);
    @(negedge clk);
    chk("R11 R2 id fall visible after three edges", {25'b0, stNoTick()}, 32'h1);
    clearAll();
    @(negedge clk); idPin = 1'b1;
    waitN(4);
    chk("R2 id rise", {25'b0, stNoTick()}, 32'h1);
  endtask

  task automatic tValidEdges();
    clearAll();
    @(negedge clk); aVbusVld = 1'b0; aSessVld = 1'b0;
    waitN(4);
    chk("R3 avbus and asess fall", {25'b0, stNoTick()}, 32'h06);
    clearAll();
    @(negedge clk); bSessVld = 1'b0;
    waitN(4);
    chk("R3 bsess fall", {25'b0, stNoTick()}, 32'h08);
    clearAll();
    @(negedge clk); aVbusVld = 1'b1; bSessVld = 1'b1;
    waitN(4);
    chk("R3 avbus and bsess rise", {25'b0, stNoTick()}, 32'h0A);
  endtask

  task automatic tSessEnd();
    clearAll();
    @(negedge clk); bSessEnd = 1'b0;
    waitN(5);
    chk("R4 fall ignored", {25'b0, stNoTick()}, 32'h0);
    @(negedge clk); bSessEnd = 1'b1;
    waitN(4);
    chk("R4 rise sets", {25'b0, stNoTick()}, 32'h10);
  endtask

  task automatic tTimer();
    int n;
    clearAll();
    n = 0;
    while (!regRdata[21] && n < 4*TICK_DIV) begin @(negedge clk); n++; end
    chk("R5 tick seen", {31'b0, regRdata[21]}, 32'h1);
    // clear it on the next edge, then count edges until it returns
    regWe = 1'b1; regWdata = {3'b0, enSh, 1'b0, 7'h20, 16'h0};
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
    chk("R7 tick cleared", {31'b0, regRdata[21]}, 32'h0);
    n = 1;
    while (!regRdata[21] && n < 4*TICK_DIV) begin @(negedge clk); n++; end
    chk("R5 tick period", n, TICK_DIV);
  endtask

  task automatic tPulse();
    clearAll();
    ctrlMode = 2'b11; portPowerOn = 1'b1;
    @(negedge clk); dataPulse = 1'b1;
    waitN(2); dataPulse = 1'b0;
    waitN(4);
    chk("R6 ignored with port power on", {31'b0, regRdata[22]}, 32'h0);
    portPowerOn = 1'b0; ctrlMode = 2'b10;
    @(negedge clk); dataPulse = 1'b1;
    waitN(2); dataPulse = 1'b0;
    waitN(4);
    chk("R6 ignored outside host mode", {31'b0, regRdata[22]}, 32'h0);
    ctrlMode = 2'b11;
    @(negedge clk); dataPulse = 1'b1;
    waitN(2); dataPulse = 1'b0;
    waitN(4);
    chk("R6 host mode power off sets", {25'b0, stNoTick()}, 32'h40);
  endtask

  task automatic tW1c();
    clearAll();
    @(negedge clk); idPin = 1'b0; aVbusVld = 1'b0;
    waitN(4);
    chk("R7 setup two flags", {25'b0, stNoTick()}, 32'h03);
    wrReg({3'b0, enSh, 1'b0, 7'h01, 16'h0});
    chk("R7 only written bit cleared", {25'b0, stNoTick()}, 32'h02);
    wrReg({3'b0, enSh, 1'b0, 7'h00, 16'h0});
    chk("R7 zero write no effect", {25'b0, stNoTick()}, 32'h02);
  endtask

  task automatic tSetWins();
    clearAll();
    @(negedge clk); idPin = 1'b1;
    waitN(2);
    regWe = 1'b1; regWdata = {3'b0, enSh, 1'b0, 7'h01, 16'h0};
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
    chk("R8 set beats coincident clear", {31'b0, regRdata[16]}, 32'h1);
  endtask

  task automatic tEnables();
    enSh = 5'b10101;
    wrReg({3'b0, enSh, 1'b0, 7'h00, 16'h0});
    chk("R9 enables read back", {27'b0, regRdata[28:24]}, 32'h15);
    wrReg(32'hE080_FFFF | {3'b0, 5'b01010, 24'h0});
    enSh = 5'b01010;
    chk("R9 reserved bits zero", regRdata & 32'hE080_FFFF, 32'h0);
    chk("R9 enables reloaded", {27'b0, regRdata[28:24]}, 32'h0A);
  endtask

  task automatic tIrq();
    enSh = 5'b00001;
    clearAll();
    waitN(TICK_DIV + 2);
    chk("R10 tick flag gated by disabled parameter", {31'b0, irq}, 32'h0);
    @(negedge clk); idPin = 1'b0;
    waitN(4);
    chk("R10 enabled id raises irq", {31'b0, irq}, 32'h1);
    enSh = 5'b00000;
    wrReg({3'b0, enSh, 1'b0, 7'h00, 16'h0});
    chk("R10 disable drops irq with flag kept", {30'b0, regRdata[16], irq}, 32'h2);
    @(negedge clk); dataPulse = 1'b1;
    waitN(2); dataPulse = 1'b0;
    waitN(4);
    chk("R10 pulse flag enabled by parameter", {31'b0, irq}, 32'h1);
  endtask

  initial begin
    tReset();
    tIdEdges();
    tValidEdges();
    tSessEnd();
    tTimer();
    tPulse();
    tW1c();
    tSetWins();
    tEnables();
    tIrq();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule